// File: doc/BRIEF.md
# Direct-Mapped Read Cache Controller

This block is a small read-only cache placed between a processor's load port and a slower backing memory. Every 32-bit request address is cut into three fields: a tag, a line index and a byte offset inside the 32-byte block. Each of the four lines keeps one tag and one valid flag. A given block can live in only one line, the one its index selects.

A processor request is accepted only while the controller is idle. On acceptance the controller captures the address and raises its wait output while it resolves the access. A hit is answered after a single wait cycle. A miss first pulls the whole block from the backing memory, one 32-bit word per handshake beat, and writes it into the indexed line. The controller then answers the processor. The answer is the 32-bit word picked by address bits 4:2. It is shown for one cycle with a response strobe, and wait is low during that cycle.

Top module: `dm_read_cache`

## Requirements
- R1: The address is split as tag = bits 31:7 (25 bits), line index = bits 6:5, and word select = bits 4:2. Bits 1:0 do not affect the result.
- R2: After reset every valid flag is clear and `cpu_wait`, `cpu_rvalid` and `mem_rd_valid` are low. The first access to each line is therefore a miss.
- R3: `cpu_req` is sampled only while the controller is idle (`cpu_wait` and `cpu_rvalid` both low). `cpu_addr` is captured at the same clock edge.
- R4: `cpu_wait` is high from the cycle after acceptance up to the cycle before the response. `cpu_rvalid` is high for exactly one cycle, and `cpu_wait` is low in that cycle.
- R5: A hit (valid flag set and stored tag equal to the address tag) gives exactly one wait cycle and no backing-memory beats.
- R6: A miss makes exactly 8 read beats. Beat k asks for word address {tag, index, 5'b0} + 4*k. A beat completes at the edge where `mem_rd_valid` and `mem_rd_ready` are both high. While ready is low, valid and the address stay unchanged.
- R7: After the last beat the line holds the new block and tag with its valid flag set. The response carries the fetched word chosen by bits 4:2.
- R8: A request raised while the controller is busy is ignored. It produces no response and no memory traffic.
- R9: An access whose tag differs from the stored tag of its line is a miss and replaces that line. The previous block then misses on its next access.
- R10: A hit returns the word stored in the line at the word position selected by the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor read request |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wait | output | 1 | Access in progress |
| cpu_rvalid | output | 1 | Response strobe, one cycle |
| cpu_rdata | output | 32 | Response word |
| mem_rd_valid | output | 1 | Backing memory beat request |
| mem_rd_addr | output | 32 | Byte address of the requested word |
| mem_rd_ready | input | 1 | Beat accepted, data valid |
| mem_rd_data | input | 32 | Word returned for the beat |

## Verification
The embedded assertions watch the per-cycle sequencing on every clock. They check that an accepted request raises wait on the next cycle, that a lookup hit leads straight to the response and a lookup miss leads straight to beats, that a stalled beat holds its address, that the response strobe lasts one cycle, that the captured address does not move while busy, and that an install makes the line hit. Only the bench scenarios can show the returned data values, the exact beat address order, the eviction of one tag by another on the same line, the reset-time misses on all lines and the silent dropping of stray requests. The bench's scoreboard compares these against a reference model of the tags and memory contents.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOOKUP = 2'd1,
      ST_FILL   = 2'd2,
      ST_RESP   = 2'd3
   } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int TAG_W = 25,
   parameter int IDX_W = 2,
   localparam int LINES = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             hit,
   input  logic             inst_en,
   input  logic [IDX_W-1:0] inst_idx,
   input  logic [TAG_W-1:0] inst_tag
);
   logic [LINES-1:0] line_hit;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic             v_q;
      logic [TAG_W-1:0] t_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= '0;
         end else if (inst_en && inst_idx == IDX_W'(g)) begin
            v_q <= 1'b1;
            t_q <= inst_tag;
         end
      end
      assign line_hit[g] = v_q && (t_q == lk_tag);
   end

   assign hit = line_hit[lk_idx];

   AST_INSTALL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (inst_en && lk_idx == inst_idx && lk_tag == inst_tag) |=> hit); // R7
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int WORD_W = 32,
   parameter int IDX_W  = 2,
   parameter int WSEL_W = 3,
   localparam int ENTRIES = 1 << (IDX_W + WSEL_W)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WSEL_W-1:0] wr_wsel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WSEL_W-1:0] rd_wsel,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] mem_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[{wr_idx, wr_wsel}] <= wr_data;
   end

   assign rd_data = mem_q[{rd_idx, rd_wsel}];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
   import dmc_pkg::*;
#(
   parameter int WSEL_W = 3,
   localparam int BEATS = 1 << WSEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              hit,
   input  logic              mem_rd_ready,
   output logic              accept,
   output logic              cpu_wait,
   output logic              cpu_rvalid,
   output logic              mem_rd_valid,
   output logic [WSEL_W-1:0] beat,
   output logic              fill_we,
   output logic              install
);
   dmc_state_e st_q, st_d;
   logic [WSEL_W-1:0] beat_q;
   logic              last_beat;

   assign last_beat    = (beat_q == WSEL_W'(BEATS - 1));
   assign accept       = (st_q == ST_IDLE) && cpu_req;
   assign cpu_wait     = (st_q == ST_LOOKUP) || (st_q == ST_FILL);
   assign cpu_rvalid   = (st_q == ST_RESP);
   assign mem_rd_valid = (st_q == ST_FILL);
   assign fill_we      = mem_rd_valid && mem_rd_ready;
   assign install      = fill_we && last_beat;
   assign beat         = beat_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (cpu_req) st_d = ST_LOOKUP;
         ST_LOOKUP: st_d = hit ? ST_RESP : ST_FILL;
         ST_FILL:   if (install) st_d = ST_RESP;
         ST_RESP:   st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         beat_q <= '0;
      end else begin
         st_q <= st_d;
         if (fill_we) beat_q <= last_beat ? '0 : beat_q + 1'b1;
      end
   end

   AST_ACCEPT_RAISES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> cpu_wait); // R4
   AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |=> (!cpu_rvalid && !cpu_wait)); // R4
   AST_HIT_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wait && !mem_rd_valid && hit) |=> cpu_rvalid); // R5
   AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(beat))); // R6
endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int NUM_LINES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_wait,
   output logic              cpu_rvalid,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              mem_rd_valid,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ready,
   input  logic [WORD_W-1:0] mem_rd_data
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(NUM_LINES);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int BSEL_W = $clog2(WORD_W / 8);
   localparam int WSEL_W = OFF_W - BSEL_W;

   initial begin : p_param_chk
      AST_PARAM_LINE_POW2: assert ((1 << OFF_W) == LINE_BYTES); // R1
      AST_PARAM_LINES_POW2: assert ((1 << IDX_W) == NUM_LINES); // R1
      AST_PARAM_WORD_BYTES: assert (WORD_W % 8 == 0 && (8 << BSEL_W) == WORD_W); // R1
      AST_PARAM_TAG_WIDTH: assert (TAG_W > 0 && WSEL_W > 0); // R1
   end

   logic [ADDR_W-1:0] addr_q;
   logic [TAG_W-1:0]  a_tag;
   logic [IDX_W-1:0]  a_idx;
   logic [WSEL_W-1:0] a_wsel;
   logic              hit, accept, fill_we, install;
   logic [WSEL_W-1:0] beat;

   always_ff @(posedge clk) begin
      if (!rst_n)      addr_q <= '0;
      else if (accept) addr_q <= cpu_addr;
   end

   assign a_tag  = addr_q[ADDR_W-1 -: TAG_W];
   assign a_idx  = addr_q[OFF_W +: IDX_W];
   assign a_wsel = addr_q[BSEL_W +: WSEL_W];
   assign mem_rd_addr = {addr_q[ADDR_W-1:OFF_W], beat, {BSEL_W{1'b0}}};

   dmc_ctrl #(.WSEL_W(WSEL_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_req     (cpu_req),
      .hit         (hit),
      .mem_rd_ready(mem_rd_ready),
      .accept      (accept),
      .cpu_wait    (cpu_wait),
      .cpu_rvalid  (cpu_rvalid),
      .mem_rd_valid(mem_rd_valid),
      .beat        (beat),
      .fill_we     (fill_we),
      .install     (install)
   );

   dmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_idx  (a_idx),
      .lk_tag  (a_tag),
      .hit     (hit),
      .inst_en (install),
      .inst_idx(a_idx),
      .inst_tag(a_tag)
   );

   dmc_data_store #(.WORD_W(WORD_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
      .clk    (clk),
      .wr_en  (fill_we),
      .wr_idx (a_idx),
      .wr_wsel(beat),
      .wr_data(mem_rd_data),
      .rd_idx (a_idx),
      .rd_wsel(a_wsel),
      .rd_data(cpu_rdata)
   );

   AST_MISS_STARTS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wait && !mem_rd_valid && !hit) |=> mem_rd_valid); // R6
   AST_ADDR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wait |=> $stable(addr_q)); // R8
   AST_NO_BEATS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> cpu_wait); // R3
endmodule

// File: tb/dm_read_cache_test.sv
module dm_read_cache_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic        cpu_wait, cpu_rvalid;
   logic [31:0] cpu_rdata;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_ready = 1'b0;
   logic [31:0] mem_rd_data;

   always #5 clk = ~clk;

   dm_read_cache uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
      .cpu_wait(cpu_wait), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
   endfunction

   // backing memory: data follows address, ready from an LFSR pattern
   logic [7:0] lfsr = 8'h5B;
   assign mem_rd_data = mem_word(mem_rd_addr);
   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rd_ready <= lfsr[1] | lfsr[4];
   end

   int n_tests = 0, n_fail = 0, n_pushed = 0, n_resp = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   typedef struct {
      logic [31:0] addr;
      logic [31:0] data;
      bit          hit;
   } item_t;
   item_t sb_q[$];

   // reference tag model
   bit          m_vld [4];
   logic [24:0] m_tag [4];

   task automatic wait_idle();
      do @(negedge clk); while (cpu_wait || cpu_rvalid);
   endtask

   task automatic rd(input logic [31:0] a);
      item_t it;
      logic [1:0] idx;
      wait_idle();
      idx = a[6:5];
      it.addr = a;
      it.data = mem_word({a[31:2], 2'b00});
      it.hit  = m_vld[idx] && (m_tag[idx] == a[31:7]);
      m_vld[idx] = 1'b1;
      m_tag[idx] = a[31:7];
      sb_q.push_back(it);
      n_pushed++;
      cpu_req  = 1'b1;
      cpu_addr = a;
      @(negedge clk);
      cpu_req  = 1'b0;
      cpu_addr = 32'hDEAD_BEEF;
   endtask

   // R8: stray request while busy with a miss
   task automatic rd_stray(input logic [31:0] a, input logic [31:0] stray);
      rd(a);
      repeat (3) @(negedge clk);
      cpu_req  = 1'b1;
      cpu_addr = stray;
      @(negedge clk);
      cpu_req  = 1'b0;
   endtask

   // monitor / scoreboard
   int wcnt = 0, beats = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (cpu_wait) wcnt++;
         if (cpu_wait && cpu_rvalid) chk(1'b0, "R4 wait during response", 32'd1, 32'd0);
         if (mem_rd_valid && mem_rd_ready) begin
            if (sb_q.size() == 0) chk(1'b0, "R8 beat with no request", mem_rd_addr, 32'd0);
            else chk(mem_rd_addr == ({sb_q[0].addr[31:5], 5'b0} + 32'(beats * 4)),
                     "R6 beat address", mem_rd_addr, {sb_q[0].addr[31:5], 5'b0} + 32'(beats * 4));
            beats++;
         end
         if (cpu_rvalid) begin
            n_resp++;
            if (sb_q.size() == 0) chk(1'b0, "R8 unexpected response", cpu_rdata, 32'd0);
            else begin
               item_t it;
               it = sb_q.pop_front();
               chk(cpu_rdata == it.data, it.hit ? "R10 hit data" : "R7 fill data", cpu_rdata, it.data);
               if (it.hit) begin
                  chk(wcnt == 1, "R5 hit wait cycles", wcnt, 1);
                  chk(beats == 0, "R5 hit beats", beats, 0);
               end else begin
                  chk(beats == 8, "R6 miss beat count", beats, 8);
                  chk(wcnt >= 9, "R4 miss wait cycles", wcnt, 9);
               end
            end
            wcnt = 0;
            beats = 0;
         end
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         chk(1'b0, "watchdog", cyc, 100000);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) m_vld[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!cpu_wait, "R2 reset wait", cpu_wait, 0);
      chk(!cpu_rvalid, "R2 reset rvalid", cpu_rvalid, 0);
      chk(!mem_rd_valid, "R2 reset mem valid", mem_rd_valid, 0);
      // R2: first access per line misses (model predicts miss)
      for (int i = 0; i < 4; i++) rd(32'h0000_1000 + 32'(i * 32) + 32'(i * 4));
      // R10, R1: hits at other words, low bits ignored
      for (int i = 0; i < 4; i++) rd(32'h0000_1000 + 32'(i * 32) + 32'((7 - i) * 4) + 32'(i & 3));
      // R9: conflict on line 0
      rd(32'h0000_2008);
      rd(32'h0000_1010);
      rd(32'h0000_2000);
      rd(32'h0000_201C);
      // R1: all-ones tag bits
      rd(32'hFFFF_FFFC);
      rd(32'hFFFF_FFE5);
      // R8: stray request during a miss to line 2, then verify line 2 kept old tag
      rd_stray(32'h0000_3044, 32'h0000_5040);
      rd(32'h0000_3058);
      rd(32'h0000_3040);
      wait_idle();
      repeat (20) @(negedge clk);
      chk(sb_q.size() == 0, "R3 pending items", sb_q.size(), 0);
      chk(n_resp == n_pushed, "R8 response count", n_resp, n_pushed);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule